// File: doc/BRIEF.md
# Opportunistic DRAM Refresh Scheduler

This block decides when a DRAM array that sits behind a bus slave gets its next row refresh. It does not fire refreshes at a fixed moment. Each one is slipped into slack that the bus already provides, so that accesses to this board almost never have to wait.

A cycle counter measures the time since the last completed refresh. Once the counter passes a window threshold, two kinds of event each trigger a refresh at once:
- the read path reports that read data is latched, because the array is then free whatever the bus still does;
- a bus cycle is seen that is addressed to another board.

If the deadline passes and neither event has occurred, the request stays pending. The next access to this board is then held off with a wait signal, and the refresh runs before that access.

Each request appears as a one-cycle pulse. The memory controller answers it with a refresh-done acknowledge, which advances a wrapping row counter and restarts the interval timer.

The FSM has five states:
- COUNT: the timer is still below the window threshold.
- ARMED: inside the window; hidden and forced refreshes are allowed.
- DUE: the deadline has passed and the request is pending.
- REQ: the one-cycle request pulse.
- BUSY: waiting for the acknowledge.

The transitions are:
- COUNT→ARMED when the timer reaches the window threshold.
- ARMED→REQ on a read-latched event or a foreign bus cycle.
- ARMED→DUE when the timer reaches the deadline.
- DUE→REQ on any bus activity or a read-latched event.
- REQ→BUSY always.
- BUSY→COUNT on the acknowledge.

With the default parameters and a 200 MHz clock, the window opens at 11 µs (2200 cycles) and the deadline is 15 µs (3000 cycles). 256 rows then cover about 4 ms.

Top module: `opp_refresh_sched`

## Requirements
- R1: During and straight after reset, refresh_req and access_wait are 0 and refresh_row is 0.
- R2: No refresh_req is issued while fewer than WIN_CYC cycles have elapsed since reset or since the last accepted refresh_ack, whatever the bus inputs do; an accepted refresh_ack restarts this count at zero.
- R3: When rdata_latched is 1 in a cycle in which at least WIN_CYC cycles have elapsed, refresh_req is 1 in the next cycle and access_wait stays 0.
- R4: When bus_active=1 and board_sel=0 in a cycle in which at least WIN_CYC cycles have elapsed, refresh_req is 1 in the next cycle and access_wait stays 0.
- R5: An access to this board (bus_active=1, board_sel=1, rdata_latched=0) while fewer than TICK_CYC cycles have elapsed causes neither refresh_req nor access_wait.
- R6: An access to this board once at least TICK_CYC cycles have elapsed raises access_wait in that same cycle, gives refresh_req in the next cycle, and keeps access_wait at 1 until the refresh_ack is accepted; access_wait is 0 in the cycle after that.
- R7: refresh_req lasts exactly one cycle, and no further refresh_req appears until the pending refresh has been acknowledged.
- R8: refresh_ack is accepted in any cycle after the refresh_req pulse and then increments refresh_row by one modulo 2^ROW_W; a refresh_ack at any other time is ignored and leaves refresh_row unchanged.
- R9: Once at least TICK_CYC cycles have elapsed with no bus activity, the request stays pending with refresh_req and access_wait both 0 until an opportunity arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_active | input | 1 | A bus cycle is in progress |
| board_sel | input | 1 | The bus cycle addresses this board |
| rdata_latched | input | 1 | The read cycle of the array has finished and the data is latched |
| refresh_ack | input | 1 | The memory controller has completed the requested refresh |
| refresh_req | output | 1 | One-cycle pulse requesting a row refresh |
| access_wait | output | 1 | Holds off the access to this board until the refresh is done |
| refresh_row | output | ROW_W | Row to refresh next; wraps around |

## Verification
A wrong internal state shows at the ports within one cycle of the next bus event. A timer that is too fast or too slow moves the first cycle in which a foreign cycle or a read-latched event yields refresh_req. A lost DUE state shows as access_wait missing in the very cycle of an own access past the deadline. A lost held flag shows as access_wait dropping before the acknowledge.

The bench sweeps the event offset over every cycle from zero to past the deadline, for all three kinds of event. Each boundary is therefore hit exactly, and every acknowledge is checked against a row value that the bench predicts arithmetically.

// File: rtl/opp_refresh_pkg.sv
package opp_refresh_pkg;

    typedef enum logic [2:0] {
        ST_COUNT,
        ST_ARMED,
        ST_DUE,
        ST_REQ,
        ST_BUSY
    } rs_state_t;

endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
    parameter int WIN_CYC  = 2200,
    parameter int TICK_CYC = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic win_hit,
    output logic due_hit
);
    localparam int CW = $clog2(TICK_CYC + 1);
    localparam logic [CW-1:0] WIN_M1  = CW'(WIN_CYC - 1);
    localparam logic [CW-1:0] TICK_M1 = CW'(TICK_CYC - 1);
    localparam logic [CW-1:0] TICK_V  = CW'(TICK_CYC);

    logic [CW-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            elapsed <= '0;
        end else if (run && elapsed != TICK_V) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign win_hit = run && (elapsed == WIN_M1);
    assign due_hit = run && (elapsed == TICK_M1);

endmodule

// File: rtl/rs_event_decode.sv
module rs_event_decode (
    input  logic bus_active,
    input  logic board_sel,
    input  logic rdata_latched,
    output logic hide_op,
    output logic force_op,
    output logic own_op
);
    assign hide_op  = rdata_latched;
    assign force_op = bus_active && !board_sel;
    assign own_op   = bus_active && board_sel && !rdata_latched;
endmodule

// File: rtl/rs_row_counter.sv
module rs_row_counter #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (bump) begin
            row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/opp_refresh_sched.sv
module opp_refresh_sched
    import opp_refresh_pkg::*;
#(
    parameter int WIN_CYC  = 2200,
    parameter int TICK_CYC = 3000,
    parameter int ROW_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_active,
    input  logic             board_sel,
    input  logic             rdata_latched,
    input  logic             refresh_ack,
    output logic             refresh_req,
    output logic             access_wait,
    output logic [ROW_W-1:0] refresh_row
);
    rs_state_t state, state_d;
    logic held, held_d;
    logic hide_op, force_op, own_op;
    logic win_hit, due_hit;
    logic timer_run, timer_clr, row_bump;

    rs_event_decode u_dec (
        .bus_active    (bus_active),
        .board_sel     (board_sel),
        .rdata_latched (rdata_latched),
        .hide_op       (hide_op),
        .force_op      (force_op),
        .own_op        (own_op)
    );

    rs_interval_timer #(
        .WIN_CYC  (WIN_CYC),
        .TICK_CYC (TICK_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .clear   (timer_clr),
        .win_hit (win_hit),
        .due_hit (due_hit)
    );

    rs_row_counter #(
        .ROW_W (ROW_W)
    ) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (row_bump),
        .row   (refresh_row)
    );

    // next-state decode
    always_comb begin
        state_d = state;
        held_d  = held;
        unique case (state)
            ST_COUNT: begin
                if (win_hit) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (hide_op || force_op) begin
                    state_d = ST_REQ;
                    held_d  = 1'b0;
                end else if (due_hit) begin
                    state_d = ST_DUE;
                end
            end
            ST_DUE: begin
                if (hide_op || force_op || own_op) begin
                    state_d = ST_REQ;
                    held_d  = own_op;
                end
            end
            ST_REQ: begin
                state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (refresh_ack) begin
                    state_d = ST_COUNT;
                    held_d  = 1'b0;
                end
            end
            default: begin
                state_d = ST_COUNT;
                held_d  = 1'b0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_COUNT;
            held  <= 1'b0;
        end else begin
            state <= state_d;
            held  <= held_d;
        end
    end

    // outputs
    always_comb begin
        refresh_req = 1'b0;
        access_wait = 1'b0;
        timer_run   = 1'b0;
        timer_clr   = 1'b0;
        row_bump    = 1'b0;
        unique case (state)
            ST_COUNT, ST_ARMED: begin
                timer_run = 1'b1;
            end
            ST_DUE: begin
                timer_run   = 1'b1;
                access_wait = own_op;
            end
            ST_REQ: begin
                refresh_req = 1'b1;
                access_wait = held;
            end
            ST_BUSY: begin
                access_wait = held;
                if (refresh_ack) begin
                    timer_clr = 1'b1;
                    row_bump  = 1'b1;
                end
            end
            default: begin
                timer_clr = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/opp_refresh_sched_chk.sv
module opp_refresh_sched_chk #(
    parameter int WIN_CYC  = 2200,
    parameter int TICK_CYC = 3000,
    parameter int ROW_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_active,
    input logic             board_sel,
    input logic             refresh_ack,
    input logic             refresh_req,
    input logic             access_wait,
    input logic [ROW_W-1:0] refresh_row
);
    localparam int SW = $clog2(TICK_CYC + 2) + 1;
    localparam logic [SW-1:0] SMAX = '1;

    logic [SW-1:0]    since;
    logic [ROW_W-1:0] row_q;

    // cycles since reset or since the last row change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since <= '0;
            row_q <= '0;
        end else begin
            row_q <= refresh_row;
            if (refresh_row != row_q) since <= SW'(1);
            else if (since != SMAX)   since <= since + 1'b1;
        end
    end

    AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> (since > SW'(WIN_CYC))); // R2

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> !refresh_req); // R7

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(refresh_row) |-> (refresh_row == ROW_W'($past(refresh_row) + 1'b1))); // R8

    AST_ROW_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(refresh_row) |-> $past(refresh_ack)); // R8

    AST_WAIT_ON_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_wait) |-> (bus_active && board_sel)); // R6

endmodule

bind opp_refresh_sched opp_refresh_sched_chk #(
    .WIN_CYC  (WIN_CYC),
    .TICK_CYC (TICK_CYC),
    .ROW_W    (ROW_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_active  (bus_active),
    .board_sel   (board_sel),
    .refresh_ack (refresh_ack),
    .refresh_req (refresh_req),
    .access_wait (access_wait),
    .refresh_row (refresh_row)
);

// File: tb/opp_refresh_sched_test.sv
`timescale 1ns/1ps
module opp_refresh_sched_test;
    localparam int WIN  = 28;
    localparam int TICK = 40;
    localparam int RW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_active = 1'b0, board_sel = 1'b0, rdata_latched = 1'b0, refresh_ack = 1'b0;
    logic refresh_req, access_wait;
    logic [RW-1:0] refresh_row;

    int tests = 0;
    int fails = 0;
    int exp_row = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    opp_refresh_sched #(.WIN_CYC(WIN), .TICK_CYC(TICK), .ROW_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .board_sel(board_sel),
        .rdata_latched(rdata_latched), .refresh_ack(refresh_ack),
        .refresh_req(refresh_req), .access_wait(access_wait), .refresh_row(refresh_row)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at the falling edge of the cycle that shows refresh_req
    task automatic finish_ref(input bit held);
        step();
        chk("R7 req single cycle", int'(refresh_req), 0);
        if (held) chk("R6 wait kept before ack", int'(access_wait), 1);
        repeat (3) step();
        chk("R7 no repeat before ack", int'(refresh_req), 0);
        refresh_ack = 1'b1;
        step();
        refresh_ack = 1'b0;
        exp_row = (exp_row + 1) % (1 << RW);
        chk("R8 row step", int'(refresh_row), exp_row);
        chk("R6 wait released after ack", int'(access_wait), 0);
    endtask

    task automatic resync();
        repeat (TICK + 2) step();
        chk("R9 pending no req", int'(refresh_req), 0);
        chk("R9 pending no wait", int'(access_wait), 0);
        bus_active = 1'b1; board_sel = 1'b0;
        step();
        bus_active = 1'b0;
        chk("R4 forced after deadline", int'(refresh_req), 1);
        if (refresh_req) finish_ref(1'b0);
    endtask

    initial begin
        repeat (3) step();
        chk("R1 req in reset", int'(refresh_req), 0);
        chk("R1 wait in reset", int'(access_wait), 0);
        chk("R1 row in reset", int'(refresh_row), 0);
        rst_n = 1'b1;
        step();
        chk("R1 req after reset", int'(refresh_req), 0);
        // stray acknowledge while nothing is pending
        refresh_ack = 1'b1;
        step();
        refresh_ack = 1'b0;
        step();
        chk("R8 stray ack ignored", int'(refresh_row), 0);
        resync();

        for (int k = 0; k < 3; k++) begin
            for (int d = 0; d <= TICK + 2; d++) begin
                bit exp_req, exp_wait;
                repeat (d) step();
                case (k)
                    0: rdata_latched = 1'b1;
                    1: begin bus_active = 1'b1; board_sel = 1'b0; end
                    default: begin bus_active = 1'b1; board_sel = 1'b1; end
                endcase
                #1;
                exp_wait = (k == 2) && (d >= TICK);
                chk(k == 2 ? (exp_wait ? "R6 wait same cycle" : "R5 no wait early")
                           : (k == 0 ? "R3 no wait" : "R4 no wait"),
                    int'(access_wait), int'(exp_wait));
                step();
                rdata_latched = 1'b0; bus_active = 1'b0; board_sel = 1'b0;
                exp_req = (k == 2) ? (d >= TICK) : (d >= WIN);
                if (d < WIN)
                    chk("R2 no req before window", int'(refresh_req), 0);
                else if (k == 0)
                    chk("R3 hidden req", int'(refresh_req), int'(exp_req));
                else if (k == 1)
                    chk("R4 forced req", int'(refresh_req), int'(exp_req));
                else
                    chk(exp_req ? "R6 req after wait" : "R5 no req early",
                        int'(refresh_req), int'(exp_req));
                if (k != 2 && d >= WIN)
                    chk("R3 R4 wait stays low", int'(access_wait), 0);
                if (exp_wait)
                    chk("R6 wait during req", int'(access_wait), 1);
                if (refresh_req) finish_ref(exp_wait);
                else resync();
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule